// File: doc/BRIEF.md
# Overflow-Driven Timestamp Unit

This block keeps elapsed time for a system whose only time base is a free-running 8-bit tick counter. The tick counter advances once every 4 us and wraps after 256 ticks, so each wrap spans 1024 us. The counter sits outside this block. The block receives two things from it: a one-cycle pulse each time a wrap is to be accounted for, and the live 8-bit count. A separate flag tells the block that a wrap has happened but its pulse has not yet arrived.

On every accounted wrap the block advances three values:
- a 32-bit wrap counter;
- a 32-bit whole-millisecond counter;
- a fractional-millisecond remainder, held in 8 us units.

Each wrap contributes 1 ms plus 3 units of 8 us. When the remainder reaches 125 units (1 ms), 125 is taken off it and an extra millisecond is added in the same update.

Two read ports return consistent values that no update can tear:
- The millisecond port answers in the next cycle.
- The microsecond port captures the wrap counter and the live count in the same cycle. It then corrects for a pending wrap in a second step, and scales the result in a third.

The microsecond sequencer moves through three named states:
- US_IDLE: waiting. A request moves it to US_ADJ and captures the operands.
- US_ADJ: applies the pending-wrap correction, then moves to US_SCALE.
- US_SCALE: forms the result, raises the acknowledge and returns to US_IDLE.

The millisecond responder has two states. MS_IDLE goes to MS_RESP on a request. MS_RESP stays in MS_RESP while requests keep coming, and otherwise returns to MS_IDLE.

The update logic classifies each cycle as one of three kinds:
- UPD_HOLD: no pulse.
- UPD_STEP: a pulse without a remainder carry.
- UPD_CARRY: a pulse with a remainder carry.

Top module: `ts_stamp_unit`

## Requirements
- R1: Each cycle with `ovf_evt` high increments the wrap counter by exactly one, modulo 2^32. Without a pulse the wrap counter holds.
- R2: Each pulse adds 1 to the millisecond counter when the remainder does not carry. Without a pulse the millisecond counter holds.
- R3: Each pulse adds 3 to the remainder. If the sum is 125 or more, 125 is subtracted and the millisecond counter gains 2 instead of 1. Starting from reset, 41 pulses give 41 ms and the 42nd pulse gives 43 ms.
- R4: After reset every counter is zero. A millisecond read returns 0. A microsecond read with a live count of 0 and no pending wrap returns 0. `ms_ack`, `us_ack` and `us_busy` are low.
- R5: `ms_req` high in cycle N makes `ms_ack` high in cycle N+1. `ms_rdata` then holds the millisecond counter as it stood before any pulse in cycle N.
- R6: A `us_req` accepted in cycle N captures the wrap counter (as before any pulse in cycle N), `tick_cnt` and `ovf_pend` of cycle N. `us_ack` is high for exactly one cycle, N+3, with `us_rdata` valid.
- R7: If the captured `ovf_pend` is 1 and the captured tick count is below 255, the captured wrap count is increased by one. With a tick count of 255 no correction is made.
- R8: `us_rdata` = ((corrected wrap count << 8) + captured tick count) × 4, modulo 2^32.
- R9: `us_busy` is high in cycles N+1 and N+2 after an accepted request. A `us_req` while `us_busy` is high is ignored and produces no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ovf_evt | input | 1 | One-cycle pulse: account for one tick-counter wrap |
| ovf_pend | input | 1 | A wrap has occurred whose pulse is still outstanding |
| tick_cnt | input | 8 | Live tick count |
| ms_req | input | 1 | Millisecond read request |
| ms_ack | output | 1 | Millisecond result valid |
| ms_rdata | output | 32 | Elapsed milliseconds |
| us_req | input | 1 | Microsecond read request |
| us_busy | output | 1 | Microsecond read in progress; requests ignored |
| us_ack | output | 1 | Microsecond result valid, one cycle |
| us_rdata | output | 32 | Elapsed microseconds |

## Verification
The assertions make only two assumptions about the inputs:
- reset is held across at least one clock edge;
- `ovf_evt` is sampled once per cycle.

Every other input pattern is legal, including pulses and requests in the same cycle and requests while busy. The stimulus draws pulses, pending flags, tick counts and requests freely from a seeded generator. It weights the tick count toward 255 so that the boundary of the correction occurs often. It adds directed sequences for the remainder carry, read/update collisions and the pending-wrap boundary.

// File: rtl/ts_pkg.sv
package ts_pkg;
    typedef enum logic [1:0] {
        US_IDLE  = 2'd0,
        US_ADJ   = 2'd1,
        US_SCALE = 2'd2
    } us_state_e;

    typedef enum logic {
        MS_IDLE = 1'b0,
        MS_RESP = 1'b1
    } ms_state_e;

    typedef enum logic [1:0] {
        UPD_HOLD  = 2'd0,
        UPD_STEP  = 2'd1,
        UPD_CARRY = 2'd2
    } upd_kind_e;
endpackage

// File: rtl/ts_accum.sv
module ts_accum
    import ts_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int FRAC_INC = 3,
    parameter int FRAC_LIM = 125,
    parameter int MS_WHOLE = 1,
    parameter int FRAC_W   = $clog2(FRAC_LIM + FRAC_INC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ovf_evt,
    output logic [CNT_W-1:0]  ovf_cnt,
    output logic [CNT_W-1:0]  ms_cnt,
    output logic [FRAC_W-1:0] frac_acc
);
    localparam logic [FRAC_W-1:0] INC_V   = FRAC_W'(FRAC_INC);
    localparam logic [FRAC_W-1:0] LIM_V   = FRAC_W'(FRAC_LIM);
    localparam logic [CNT_W-1:0]  WHOLE_V = CNT_W'(MS_WHOLE);

    upd_kind_e         kind;
    logic [FRAC_W-1:0] frac_sum;
    logic [FRAC_W-1:0] frac_nx;
    logic [CNT_W-1:0]  ovf_nx;
    logic [CNT_W-1:0]  ms_nx;

    // Classify the cycle's update
    always_comb begin
        frac_sum = frac_acc + INC_V;
        if (!ovf_evt) begin
            kind = UPD_HOLD;
        end else if (frac_sum >= LIM_V) begin
            kind = UPD_CARRY;
        end else begin
            kind = UPD_STEP;
        end
    end

    // Next values per update kind
    always_comb begin
        ovf_nx  = ovf_cnt;
        ms_nx   = ms_cnt;
        frac_nx = frac_acc;
        unique case (kind)
            UPD_HOLD: begin
                ovf_nx = ovf_cnt;
            end
            UPD_STEP: begin
                ovf_nx  = ovf_cnt + 1'b1;
                ms_nx   = ms_cnt + WHOLE_V;
                frac_nx = frac_sum;
            end
            UPD_CARRY: begin
                ovf_nx  = ovf_cnt + 1'b1;
                ms_nx   = ms_cnt + WHOLE_V + 1'b1;
                frac_nx = frac_sum - LIM_V;
            end
            default: begin
                ovf_nx = ovf_cnt;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_cnt  <= '0;
            ms_cnt   <= '0;
            frac_acc <= '0;
        end else begin
            ovf_cnt  <= ovf_nx;
            ms_cnt   <= ms_nx;
            frac_acc <= frac_nx;
        end
    end
endmodule

// File: rtl/ts_ms_port.sv
module ts_ms_port
    import ts_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ms_req,
    input  logic [CNT_W-1:0] ms_cnt,
    output logic             ms_ack,
    output logic [CNT_W-1:0] ms_rdata
);
    ms_state_e st;
    ms_state_e st_nx;

    always_comb begin
        unique case (st)
            MS_IDLE: st_nx = ms_req ? MS_RESP : MS_IDLE;
            MS_RESP: st_nx = ms_req ? MS_RESP : MS_IDLE;
            default: st_nx = MS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= MS_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    // Snapshot is the registered counter, i.e. the pre-update value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ms_rdata <= '0;
        end else if (ms_req) begin
            ms_rdata <= ms_cnt;
        end
    end

    assign ms_ack = (st == MS_RESP);
endmodule

// File: rtl/ts_us_port.sv
module ts_us_port
    import ts_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int TICK_W     = 8,
    parameter int TICK_SHIFT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              us_req,
    input  logic              ovf_pend,
    input  logic [TICK_W-1:0] tick_cnt,
    input  logic [CNT_W-1:0]  ovf_cnt,
    output logic              us_busy,
    output logic              us_ack,
    output logic [CNT_W-1:0]  us_rdata
);
    localparam int WIDE_W = CNT_W + TICK_W + TICK_SHIFT;

    us_state_e          st;
    us_state_e          st_nx;
    logic [CNT_W-1:0]   cap_cnt;
    logic [TICK_W-1:0]  cap_tick;
    logic               cap_pend;
    logic               fix_due;
    logic [WIDE_W-1:0]  scaled;

    always_comb begin
        unique case (st)
            US_IDLE:  st_nx = us_req ? US_ADJ : US_IDLE;
            US_ADJ:   st_nx = US_SCALE;
            US_SCALE: st_nx = US_IDLE;
            default:  st_nx = US_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= US_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    // Correction only when the captured count has not reached its last value
    assign fix_due = cap_pend && (cap_tick != {TICK_W{1'b1}});
    assign scaled  = {{TICK_SHIFT{1'b0}}, cap_cnt, cap_tick} << TICK_SHIFT;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_cnt  <= '0;
            cap_tick <= '0;
            cap_pend <= 1'b0;
            us_ack   <= 1'b0;
            us_rdata <= '0;
        end else begin
            us_ack <= 1'b0;
            unique case (st)
                US_IDLE: begin
                    if (us_req) begin
                        cap_cnt  <= ovf_cnt;
                        cap_tick <= tick_cnt;
                        cap_pend <= ovf_pend;
                    end
                end
                US_ADJ: begin
                    if (fix_due) begin
                        cap_cnt <= cap_cnt + 1'b1;
                    end
                end
                US_SCALE: begin
                    us_rdata <= scaled[CNT_W-1:0];
                    us_ack   <= 1'b1;
                end
                default: begin
                    us_ack <= 1'b0;
                end
            endcase
        end
    end

    assign us_busy = (st != US_IDLE);
endmodule

// File: rtl/ts_stamp_unit.sv
module ts_stamp_unit
    import ts_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int TICK_W     = 8,
    parameter int TICK_SHIFT = 2,
    parameter int FRAC_INC   = 3,
    parameter int FRAC_LIM   = 125,
    parameter int MS_WHOLE   = 1,
    parameter int FRAC_W     = $clog2(FRAC_LIM + FRAC_INC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ovf_evt,
    input  logic              ovf_pend,
    input  logic [TICK_W-1:0] tick_cnt,
    input  logic              ms_req,
    output logic              ms_ack,
    output logic [CNT_W-1:0]  ms_rdata,
    input  logic              us_req,
    output logic              us_busy,
    output logic              us_ack,
    output logic [CNT_W-1:0]  us_rdata
);
    logic [CNT_W-1:0]  ovf_cnt;
    logic [CNT_W-1:0]  ms_cnt;
    logic [FRAC_W-1:0] frac_acc;

    ts_accum #(
        .CNT_W    (CNT_W),
        .FRAC_INC (FRAC_INC),
        .FRAC_LIM (FRAC_LIM),
        .MS_WHOLE (MS_WHOLE),
        .FRAC_W   (FRAC_W)
    ) i_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .ovf_evt  (ovf_evt),
        .ovf_cnt  (ovf_cnt),
        .ms_cnt   (ms_cnt),
        .frac_acc (frac_acc)
    );

    ts_ms_port #(
        .CNT_W (CNT_W)
    ) i_ms_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .ms_req   (ms_req),
        .ms_cnt   (ms_cnt),
        .ms_ack   (ms_ack),
        .ms_rdata (ms_rdata)
    );

    ts_us_port #(
        .CNT_W      (CNT_W),
        .TICK_W     (TICK_W),
        .TICK_SHIFT (TICK_SHIFT)
    ) i_us_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .us_req   (us_req),
        .ovf_pend (ovf_pend),
        .tick_cnt (tick_cnt),
        .ovf_cnt  (ovf_cnt),
        .us_busy  (us_busy),
        .us_ack   (us_ack),
        .us_rdata (us_rdata)
    );
endmodule

// File: rtl/ts_stamp_chk.sv
module ts_stamp_chk #(
    parameter int CNT_W    = 32,
    parameter int FRAC_LIM = 125,
    parameter int FRAC_W   = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ovf_evt,
    input logic              ms_req,
    input logic              ms_ack,
    input logic [CNT_W-1:0]  ms_rdata,
    input logic              us_req,
    input logic              us_busy,
    input logic              us_ack,
    input logic [CNT_W-1:0]  ovf_cnt,
    input logic [CNT_W-1:0]  ms_cnt,
    input logic [FRAC_W-1:0] frac_acc
);
    localparam logic [CNT_W-1:0]  ONE_C = CNT_W'(1);
    localparam logic [CNT_W-1:0]  TWO_C = CNT_W'(2);
    localparam logic [FRAC_W-1:0] LIM_F = FRAC_W'(FRAC_LIM);

    AST_OVF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> (ovf_cnt == $past(ovf_cnt) + ONE_C)); // R1
    AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ovf_evt |=> $stable(ovf_cnt)); // R1
    AST_MS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> ((ms_cnt - $past(ms_cnt)) == ONE_C || (ms_cnt - $past(ms_cnt)) == TWO_C)); // R2
    AST_MS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ovf_evt |=> $stable(ms_cnt)); // R2
    AST_FRAC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        frac_acc < LIM_F); // R3
    AST_MS_SNAPSHOT: assert property (@(posedge clk) disable iff (!rst_n)
        ms_req |=> (ms_ack && ms_rdata == $past(ms_cnt))); // R5
    AST_US_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        us_ack |=> !us_ack); // R6
    AST_US_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!us_busy && us_req) |=> us_busy); // R9
    AST_US_ACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        us_ack |-> !us_busy); // R9
endmodule

bind ts_stamp_unit ts_stamp_chk #(
    .CNT_W    (CNT_W),
    .FRAC_LIM (FRAC_LIM),
    .FRAC_W   (FRAC_W)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ovf_evt  (ovf_evt),
    .ms_req   (ms_req),
    .ms_ack   (ms_ack),
    .ms_rdata (ms_rdata),
    .us_req   (us_req),
    .us_busy  (us_busy),
    .us_ack   (us_ack),
    .ovf_cnt  (ovf_cnt),
    .ms_cnt   (ms_cnt),
    .frac_acc (frac_acc)
);

// File: tb/test_ts_stamp_unit.sv
module test_ts_stamp_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ovf_evt = 1'b0;
    logic        ovf_pend = 1'b0;
    logic [7:0]  tick_cnt = 8'd0;
    logic        ms_req = 1'b0;
    logic        ms_ack;
    logic [31:0] ms_rdata;
    logic        us_req = 1'b0;
    logic        us_busy;
    logic        us_ack;
    logic [31:0] us_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Reference state
    bit [31:0] m_ovf = 0;
    bit [31:0] m_ms = 0;
    int        m_frac = 0;
    bit        ms_exp_v = 1'b0;
    bit [31:0] ms_exp = 0;
    string     ms_tag = "";
    int        us_cd = 0;
    bit [31:0] us_exp = 0;
    string     us_tag = "";

    always #5 clk = ~clk;

    ts_stamp_unit i_ts_stamp_unit (
        .clk      (clk),
        .rst_n    (rst_n),
        .ovf_evt  (ovf_evt),
        .ovf_pend (ovf_pend),
        .tick_cnt (tick_cnt),
        .ms_req   (ms_req),
        .ms_ack   (ms_ack),
        .ms_rdata (ms_rdata),
        .us_req   (us_req),
        .us_busy  (us_busy),
        .us_ack   (us_ack),
        .us_rdata (us_rdata)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit [31:0] us_value(bit [31:0] cnt, bit pend, bit [7:0] t);
        bit [31:0] c;
        c = cnt + ((pend && t != 8'hFF) ? 32'd1 : 32'd0);
        return ((c << 8) + {24'd0, t}) << 2;
    endfunction

    // One cycle: check outputs, then drive new inputs and advance the model
    task automatic step(bit ovf, bit pend, bit [7:0] t, bit msr, bit usr, string tag);
        int cd_prev;
        @(negedge clk);
        if (ms_exp_v) begin
            chk("R5 ms_ack", {31'd0, ms_ack}, 32'd1);
            chk(ms_tag, ms_rdata, ms_exp);
        end else begin
            chk("R5 ms_ack idle", {31'd0, ms_ack}, 32'd0);
        end
        cd_prev = us_cd;
        if (us_cd > 0) us_cd--;
        if (cd_prev > 0 && us_cd == 0) begin
            chk("R6 us_ack", {31'd0, us_ack}, 32'd1);
            chk(us_tag, us_rdata, us_exp);
        end else begin
            chk("R9 us_ack quiet", {31'd0, us_ack}, 32'd0);
        end
        chk("R9 us_busy", {31'd0, us_busy}, {31'd0, us_cd != 0});

        ovf_evt  = ovf;
        ovf_pend = pend;
        tick_cnt = t;
        ms_req   = msr;
        us_req   = usr;

        ms_exp_v = msr;
        ms_exp   = m_ms;
        ms_tag   = tag;
        if (usr && us_cd == 0) begin
            us_cd  = 3;
            us_exp = us_value(m_ovf, pend, t);
            us_tag = tag;
        end
        if (ovf) begin
            m_ovf  = m_ovf + 1;
            m_frac = m_frac + 3;
            if (m_frac >= 125) begin
                m_frac = m_frac - 125;
                m_ms   = m_ms + 2;
            end else begin
                m_ms = m_ms + 1;
            end
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R4: reset state and zero reads
        @(negedge clk);
        chk("R4 ms_ack", {31'd0, ms_ack}, 32'd0);
        chk("R4 us_ack", {31'd0, us_ack}, 32'd0);
        chk("R4 us_busy", {31'd0, us_busy}, 32'd0);
        step(0, 0, 8'd0, 1, 1, "R4 zero read");
        repeat (4) step(0, 0, 8'd0, 0, 0, "idle");

        // R2/R3: 41 pulses give 41 ms, the 42nd gives 43 ms
        repeat (41) step(1, 0, 8'd0, 0, 0, "pulse");
        step(0, 0, 8'd0, 1, 0, "R2 forty-one ms");
        step(1, 0, 8'd0, 0, 0, "pulse");
        step(0, 0, 8'd0, 1, 0, "R3 carry to 43");
        step(0, 0, 8'd0, 0, 0, "idle");

        // R5/R6: read in the same cycle as an update returns the old value
        step(1, 0, 8'd17, 1, 1, "R5 R6 collide");
        repeat (4) step(0, 0, 8'd0, 0, 0, "idle");

        // R7: pending wrap, below and at the last tick value
        step(0, 1, 8'd254, 0, 1, "R7 pend fix");
        repeat (3) step(0, 0, 8'd0, 0, 0, "idle");
        step(0, 1, 8'd255, 0, 1, "R7 pend at 255");
        repeat (3) step(0, 0, 8'd0, 0, 0, "idle");
        // R9: back-to-back requests, second one ignored
        step(0, 0, 8'd5, 0, 1, "R9 first");
        step(0, 1, 8'd9, 0, 1, "R9 ignored");
        repeat (3) step(0, 0, 8'd0, 0, 0, "idle");

        // R8 and all others under random traffic
        for (int i = 0; i < 4000; i++) begin
            bit [7:0] t;
            t = (($urandom % 5) == 0) ? 8'hFF : 8'($urandom);
            step(($urandom % 3) == 0, ($urandom % 4) == 0, t,
                 ($urandom % 4) == 0, ($urandom % 3) == 0, "R8 random");
        end
        repeat (5) step(0, 0, 8'd0, 0, 0, "idle");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule